// File: doc/BRIEF.md
# Cascaded Interrupt Controller Register Unit

This unit gathers interrupt sources from three identical controller banks: one main bank and two sub-banks, each with 32 sources. Every bank has a small set of 32-bit registers on a simple word bus. Each source is conditioned by its own polarity bit and by its own edge or level type. Edge events are held until software clears them. The conditioned state is gated by a per-source enable, and each source is steered to either the normal IRQ path or the fast FIQ path.

The two sub-banks cascade into the main bank. The IRQ-steered requests of sub-bank 1 and sub-bank 2 take the place of main-bank sources 0 and 1. The main bank then applies its own polarity, type and enable to those two lines. Sources that a sub-bank steers to FIQ skip the main bank and drive the FIQ pin directly. Software sees one flat space of 96 source numbers, in which source `b` of bank `c` has number `b + 32*c`.

The register bus has no wait states. A write takes effect at the clock edge where it is sampled. A read is combinational from the address.

Top module: `irq_cascade_top`

## Requirements
- R1: Reset clears enable, activation-type and routing registers in all banks, sets every polarity bit to 1, and holds `irq_o` and `fiq_o` low.
- R2: Address bits [15:14] select the bank: 0 is main, 1 is sub-bank 1, 2 is sub-bank 2. Bits [4:2] select the register: 0 enable, 1 raw status, 2 masked status, 3 polarity, 4 type, 5 routing. An access is mapped only if bits [13:5] and [1:0] are zero, the bank is below 3 and the register is below 6. Unmapped reads return 0 and unmapped writes change nothing. Enable, polarity, type and routing read back the last value written.
- R3: For a level source (type bit 0), the raw-status bit follows the input in the same cycle. It equals the input when the polarity bit is 1 and the inverted input when the polarity bit is 0.
- R4: For an edge source (type bit 1), a change of the conditioned input from inactive to active sets the raw-status bit at the next clock edge. A rising input counts when polarity is 1, and a falling input counts when polarity is 0. The bit stays set until a write of 1 to that raw-status bit, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R5: Masked status equals raw status AND enable, and writes to it are ignored.
- R6: A routing bit of 0 sends the source to the IRQ path and a routing bit of 1 sends it to the FIQ path.
- R7: `irq_o` is the OR of the main bank's masked bits steered to IRQ. `fiq_o` is the OR of the masked bits steered to FIQ in all three banks.
- R8: The OR of sub-bank 1's IRQ-steered masked bits drives main source 0, and the same for sub-bank 2 drives main source 1. The main bank conditions both lines with its own polarity, type and enable.
- R9: Input `src_i[n]` is global source `n`, which is bit `n mod 32` of bank `n / 32`. Global sources 0 and 1 have no input pin.
- R10: A write to the raw-status bit of a level source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 94 | Source inputs for global numbers 95 down to 2 |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the unit with its default parameters. These are 32 sources per bank and bank selection at address bit 14, which are the values the three-bank address map and the cascade onto main sources 0 and 1 are defined for. With these values a single run covers several things:
- level sources in both polarities;
- rising and falling edge latching;
- clearing by write of 1;
- a sub-bank edge reaching `irq_o` through the main bank;
- the same edge moved to `fiq_o` when its routing bit is set.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int NUM_CTL = 3;

    typedef enum logic [2:0] {
        REG_EN  = 3'd0,
        REG_RAW = 3'd1,
        REG_MSK = 3'd2,
        REG_POL = 3'd3,
        REG_TYP = 3'd4,
        REG_RTE = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] pol,
    input  logic [SRC_W-1:0] typ,
    input  logic [SRC_W-1:0] clr,
    output logic [SRC_W-1:0] raw
);

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        logic cond;
        logic prev_q;
        logic hold_q;
        logic edge_hit;

        always_comb begin
            cond     = pol[i] ? src[i] : ~src[i];
            edge_hit = typ[i] & cond & ~prev_q;
            raw[i]   = typ[i] ? hold_q : cond;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                prev_q <= cond;
                // a new edge wins over a clear in the same cycle
                hold_q <= (hold_q & ~clr[i]) | edge_hit;
            end
        end
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_cascade_pkg::*;
#(
    parameter int               SRC_W     = 32,
    parameter logic [SRC_W-1:0] POL_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic             wr_en,
    input  logic [2:0]       reg_sel,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] rdata,
    output logic [SRC_W-1:0] masked,
    output logic [SRC_W-1:0] route
);

    logic [SRC_W-1:0] en_q;
    logic [SRC_W-1:0] pol_q;
    logic [SRC_W-1:0] typ_q;
    logic [SRC_W-1:0] rte_q;
    logic [SRC_W-1:0] raw;
    logic [SRC_W-1:0] clr;

    assign clr = (wr_en && reg_sel == REG_RAW) ? wdata : '0;

    irq_src_cond #(.SRC_W(SRC_W)) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .pol   (pol_q),
        .typ   (typ_q),
        .clr   (clr),
        .raw   (raw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= POL_RESET;
            typ_q <= '0;
            rte_q <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                REG_EN:  en_q  <= wdata;
                REG_POL: pol_q <= wdata;
                REG_TYP: typ_q <= wdata;
                REG_RTE: rte_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        masked = raw & en_q;
        route  = rte_q;
        case (reg_sel)
            REG_EN:  rdata = en_q;
            REG_RAW: rdata = raw;
            REG_MSK: rdata = masked;
            REG_POL: rdata = pol_q;
            REG_TYP: rdata = typ_q;
            REG_RTE: rdata = rte_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
    import irq_cascade_pkg::*;
#(
    parameter int  SRC_W     = 32,
    parameter int  BANK_LSB  = 14,
    localparam int TOTAL     = NUM_CTL * SRC_W,
    localparam int ADDR_W    = BANK_LSB + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:2]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SRC_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [SRC_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [1:0]                        bank_sel;
    logic [2:0]                        reg_sel;
    logic                              hit;
    logic [NUM_CTL-1:0][SRC_W-1:0]     bank_src;
    logic [NUM_CTL-1:0][SRC_W-1:0]     bank_rd;
    logic [NUM_CTL-1:0][SRC_W-1:0]     masked_w;
    logic [NUM_CTL-1:0][SRC_W-1:0]     route_w;
    logic [NUM_CTL-1:1]                casc_req;

    assign bank_sel = bus_addr[ADDR_W-1:BANK_LSB];
    assign reg_sel  = bus_addr[4:2];
    assign hit      = (bus_addr[BANK_LSB-1:5] == '0) && (bus_addr[1:0] == 2'b00)
                   && (reg_sel <= 3'(REG_RTE)) && (bank_sel < 2'(NUM_CTL));

    for (genvar c = 0; c < NUM_CTL; c++) begin : g_bank
        if (c == 0) begin : g_main
            assign bank_src[c] = {src_i[SRC_W-1:2], casc_req[2], casc_req[1]};
        end else begin : g_sub
            assign bank_src[c] = src_i[c*SRC_W +: SRC_W];
            assign casc_req[c] = |(masked_w[c] & ~route_w[c]);
        end

        irq_bank #(.SRC_W(SRC_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (bank_src[c]),
            .wr_en   (bus_we && hit && bank_sel == 2'(c)),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata),
            .rdata   (bank_rd[c]),
            .masked  (masked_w[c]),
            .route   (route_w[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        fiq_o     = 1'b0;
        for (int c = 0; c < NUM_CTL; c++) begin
            if (hit && bank_sel == 2'(c)) bus_rdata = bank_rd[c];
            fiq_o = fiq_o | (|(masked_w[c] & route_w[c]));
        end
        irq_o = |(masked_w[0] & ~route_w[0]);
    end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
    parameter int SRC_W    = 32,
    parameter int NUM_CTL  = 3,
    parameter int ADDR_W   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [SRC_W-1:0]              bus_wdata,
    input logic                          irq_o,
    input logic                          fiq_o,
    input logic [NUM_CTL-1:0][SRC_W-1:0] masked_w,
    input logic [NUM_CTL-1:0][SRC_W-1:0] route_w
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fiq_o));

    // R6
    no_fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_w == '0) |-> !fiq_o);

    // R7
    irq_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (masked_w[0] != '0));

    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0 && bus_wdata == '0) |=> (masked_w[0] == '0));

endmodule

bind irq_cascade_top irq_cascade_chk #(
    .SRC_W   (SRC_W),
    .NUM_CTL (irq_cascade_pkg::NUM_CTL),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .masked_w  (masked_w),
    .route_w   (route_w)
);

// File: tb/test_irq_cascade_top.sv
`timescale 1ns/100ps
module test_irq_cascade_top;

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_FIQ = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:2] src_i = '0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    irq_cascade_top i_irq_cascade_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    function automatic logic [15:0] ra(int bank, int off);
        return 16'((bank << 14) | off);
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'd0, irq_o};
                default: act = {31'd0, fiq_o};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.kind = K_RD; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic pin(input int k, input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.kind = k; it.exp = {31'd0, e}; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic set_src(input int n, input logic v);
        @(posedge clk); #1;
        src_i[n] = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(ra(0, 0), 32'h0, "R1 main enable");
        rd(ra(1, 16), 32'h0, "R1 sub1 type");
        rd(ra(2, 20), 32'h0, "R1 sub2 route");
        rd(ra(0, 12), 32'hFFFF_FFFF, "R1 main polarity");
        pin(K_IRQ, 1'b0, "R1 irq");
        pin(K_FIQ, 1'b0, "R1 fiq");

        // R2 map
        wr(ra(1, 0), 32'hA5A5_0000);
        rd(ra(1, 0), 32'hA5A5_0000, "R2 readback");
        rd(ra(1, 24), 32'h0, "R2 unmapped offset");
        wr(ra(3, 0), 32'hFFFF_FFFF);
        rd(ra(3, 0), 32'h0, "R2 bank 3");
        wr(ra(1, 32), 32'h0);
        rd(ra(1, 0), 32'hA5A5_0000, "R2 alias write ignored");
        wr(ra(1, 0), 32'h0);

        // R3 level, R7 irq
        wr(ra(0, 0), 32'h20);
        set_src(5, 1'b1);
        rd(ra(0, 4), 32'h20, "R3 level high");
        rd(ra(0, 8), 32'h20, "R5 masked");
        pin(K_IRQ, 1'b1, "R7 irq from level");
        pin(K_FIQ, 1'b0, "R7 fiq quiet");
        // R10 write to raw of level source
        wr(ra(0, 4), 32'hFFFF_FFFF);
        rd(ra(0, 4), 32'h20, "R10 level raw write");
        // R5 masked write ignored
        wr(ra(0, 8), 32'h0);
        rd(ra(0, 8), 32'h20, "R5 masked write ignored");
        wr(ra(0, 12), 32'hFFFF_FFDF);
        rd(ra(0, 4), 32'h0, "R3 active-low input high");
        pin(K_IRQ, 1'b0, "R3 irq active-low");
        set_src(5, 1'b0);
        rd(ra(0, 4), 32'h20, "R3 active-low input low");
        wr(ra(0, 12), 32'hFFFF_FFFF);
        wr(ra(0, 0), 32'h0);
        pin(K_IRQ, 1'b0, "R7 irq after disable");

        // R4 rising edge on global 67 (sub2 bit 3), R8 cascade
        wr(ra(2, 16), 32'h8);
        wr(ra(2, 0), 32'h8);
        wr(ra(0, 0), 32'h2);
        rd(ra(2, 4), 32'h0, "R4 no edge yet");
        set_src(67, 1'b1);
        set_src(67, 1'b0);
        rd(ra(2, 4), 32'h8, "R4 R9 edge latched");
        rd(ra(0, 4), 32'h2, "R8 sub2 drives main bit1");
        pin(K_IRQ, 1'b1, "R8 irq via cascade");
        pin(K_FIQ, 1'b0, "R8 fiq quiet");
        wr(ra(2, 4), 32'h0);
        rd(ra(2, 4), 32'h8, "R4 write 0 keeps");
        wr(ra(2, 4), 32'h8);
        rd(ra(2, 4), 32'h0, "R4 write 1 clears");
        pin(K_IRQ, 1'b0, "R8 irq cleared");

        // R6 route to FIQ
        wr(ra(2, 20), 32'h8);
        set_src(67, 1'b1);
        set_src(67, 1'b0);
        rd(ra(2, 8), 32'h8, "R5 sub2 masked");
        rd(ra(0, 4), 32'h0, "R8 fiq-routed not cascaded");
        pin(K_FIQ, 1'b1, "R6 fiq asserted");
        pin(K_IRQ, 1'b0, "R6 irq quiet");
        wr(ra(2, 4), 32'h8);
        pin(K_FIQ, 1'b0, "R7 fiq after clear");

        // R4 falling edge on global 39 (sub1 bit 7)
        wr(ra(1, 12), 32'hFFFF_FF7F);
        wr(ra(1, 16), 32'h80);
        wr(ra(1, 0), 32'h80);
        wr(ra(0, 0), 32'h3);
        rd(ra(1, 4), 32'h0, "R4 falling none yet");
        set_src(39, 1'b1);
        rd(ra(1, 4), 32'h0, "R4 rising ignored when active-low");
        set_src(39, 1'b0);
        rd(ra(1, 4), 32'h80, "R4 falling latched");
        rd(ra(0, 4), 32'h1, "R8 sub1 drives main bit0");
        pin(K_IRQ, 1'b1, "R8 irq from sub1");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule